// File: doc/BRIEF.md
# Receiver Polling-Cycle Sequencer

This block runs the periodic wake-up loop of a low-power receiver. Each pass through the loop has four phases in a fixed order. First comes a programmable sleep interval. Then the frequency synthesizer is started and the block waits for it to report lock. A fixed signal-processing settling wait follows. Last comes a bit-check window, in which an external decision stage samples the transmitter preamble. The receiver is deaf to the air interface during the sleep and both start-up phases.

The sleep interval is set by a 5-bit code and an extension bit. The interval is the code times a base step of `BASE_CYC` clock cycles, times `EXT_MUL` when the extension bit is set and times 1 when it is clear. These values are sampled only at the moment a sleep phase begins. If the bit check fails, the loop starts over from a freshly loaded sleep. If it passes, the block raises a receive flag and holds it until a clear input sends the loop back to sleep.

Top module: `rx_poll_seq`

## Requirements
- R1: While `rst_ni` is low, all five phase outputs are 0. The cycle after reset is released is a one-cycle arm step in which all outputs stay 0. The sleep phase then starts, with its length taken from the register inputs.
- R2: `sleep_o` is high for exactly `sleep_code_i * BASE_CYC * (ext_sel_i ? EXT_MUL : 1)` consecutive cycles, using the values sampled at sleep entry. The next phase is `pll_en_o`.
- R3: A sleep code of 0 skips the sleep phase. `pll_en_o` rises in the cycle right after the sleep-entry event.
- R4: `pll_en_o` stays high for as long as `pll_lock_i` is low. In the cycle after `pll_lock_i` is seen high during this phase, `sigp_en_o` is high.
- R5: `sigp_en_o` is high for exactly `SIGP_CYC` cycles, after which `bchk_en_o` goes high.
- R6: While `bchk_en_o` is high, the block holds in this phase until `bchk_done_i` is 1. Then `bchk_pass_i` = 1 moves it to the receive phase (`rx_flag_o`). `bchk_pass_i` = 0 starts a new sleep, reloaded from the current register inputs.
- R7: `rx_flag_o` stays high until `rx_clear_i` is 1. The clear starts a new sleep, reloaded from the current register inputs.
- R8: Changes to `sleep_code_i` and `ext_sel_i` during a sleep do not alter its length. `pll_lock_i`, `bchk_done_i`, `bchk_pass_i` and `rx_clear_i` have no effect outside the phase that uses each of them.
- R9: At most one of `sleep_o`, `pll_en_o`, `sigp_en_o`, `bchk_en_o`, `rx_flag_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_code_i | input | 5 | Sleep length code, in base steps |
| ext_sel_i | input | 1 | 1 multiplies the sleep length by EXT_MUL |
| pll_lock_i | input | 1 | Synthesizer lock indication |
| bchk_done_i | input | 1 | Bit-check decision valid |
| bchk_pass_i | input | 1 | Bit-check result, 1 = preamble found |
| rx_clear_i | input | 1 | Leaves the receive phase |
| sleep_o | output | 1 | Sleep phase active |
| pll_en_o | output | 1 | Synthesizer enable, start-up phase |
| sigp_en_o | output | 1 | Signal-processing start-up phase |
| bchk_en_o | output | 1 | Bit-check window open |
| rx_flag_o | output | 1 | Bit check passed; receiving |

## Verification
A phase register stuck in the wrong phase shows up on the one-hot phase outputs in the very next cycle. A sleep or settling counter with a wrong load value or a wrong step only shows up when its phase ends. The error then appears as a phase length that differs from the arithmetic value, so every legal code and extension setting is swept and each phase width is measured to the cycle. Inputs that should be ignored are driven while the design sits in other phases. The bench then confirms that neither the phase lengths nor the receive flag change.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
  typedef enum logic [2:0] {
    PH_ARM   = 3'd0,
    PH_SLEEP = 3'd1,
    PH_PLL   = 3'd2,
    PH_SIGP  = 3'd3,
    PH_BCHK  = 3'd4,
    PH_RX    = 3'd5
  } phase_e;
endpackage

// File: rtl/rx_poll_len.sv
module rx_poll_len #(
  parameter int CODE_W   = 5,
  parameter int BASE_CYC = 1024,
  parameter int EXT_MUL  = 8,
  parameter int LEN_W    = 19
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              zero_o
);
  localparam bit POW2 = ((BASE_CYC & (BASE_CYC - 1)) == 0) &&
                        ((EXT_MUL & (EXT_MUL - 1)) == 0);
  localparam int SH_B = $clog2(BASE_CYC);
  localparam int SH_E = $clog2(EXT_MUL);

  logic [LEN_W-1:0] code_x;
  assign code_x = LEN_W'(code_i);
  assign zero_o = (code_i == '0);

  generate
    if (POW2) begin : g_shift
      assign len_o = ext_i ? (code_x << (SH_B + SH_E)) : (code_x << SH_B);
    end else begin : g_mult
      logic [LEN_W-1:0] base_len;
      assign base_len = code_x * LEN_W'(BASE_CYC);
      assign len_o    = ext_i ? base_len * LEN_W'(EXT_MUL) : base_len;
    end
  endgenerate
endmodule

// File: rtl/rx_poll_dcnt.sv
module rx_poll_dcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  AST_DCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R2
  AST_DCNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic bchk_done_i,
  input  logic bchk_pass_i,
  input  logic rx_clear_i,
  input  logic len_zero_i,
  input  logic slp_zero_i,
  input  logic fix_zero_i,
  output logic slp_load_o,
  output logic slp_dec_o,
  output logic fix_load_o,
  output logic fix_dec_o,
  output logic sleep_o,
  output logic pll_en_o,
  output logic sigp_en_o,
  output logic bchk_en_o,
  output logic rx_flag_o
);
  phase_e ph_q, ph_d;
  logic   go_sleep;

  always_comb begin
    ph_d       = ph_q;
    go_sleep   = 1'b0;
    fix_load_o = 1'b0;
    slp_dec_o  = 1'b0;
    fix_dec_o  = 1'b0;
    unique case (ph_q)
      PH_ARM:   go_sleep = 1'b1;
      PH_SLEEP: if (slp_zero_i) ph_d = PH_PLL; else slp_dec_o = 1'b1;
      PH_PLL:   if (pll_lock_i) begin ph_d = PH_SIGP; fix_load_o = 1'b1; end
      PH_SIGP:  if (fix_zero_i) ph_d = PH_BCHK; else fix_dec_o = 1'b1;
      PH_BCHK:  if (bchk_done_i) begin
                  if (bchk_pass_i) ph_d = PH_RX;
                  else             go_sleep = 1'b1;
                end
      PH_RX:    if (rx_clear_i) go_sleep = 1'b1;
      default:  ph_d = PH_ARM;
    endcase
    // sleep entry: a zero-length sleep goes straight to start-up
    if (go_sleep) ph_d = len_zero_i ? PH_PLL : PH_SLEEP;
  end

  assign slp_load_o = go_sleep && !len_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_ARM;
    else         ph_q <= ph_d;
  end

  assign sleep_o   = (ph_q == PH_SLEEP);
  assign pll_en_o  = (ph_q == PH_PLL);
  assign sigp_en_o = (ph_q == PH_SIGP);
  assign bchk_en_o = (ph_q == PH_BCHK);
  assign rx_flag_o = (ph_q == PH_RX);

  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sleep_o, pll_en_o, sigp_en_o, bchk_en_o, rx_flag_o})); // R9
  AST_PLL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_o && !pll_lock_i) |=> pll_en_o); // R4
  AST_PLL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_o && pll_lock_i) |=> sigp_en_o); // R4
  AST_SIGP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sigp_en_o && fix_zero_i) |=> bchk_en_o); // R5
  AST_BCHK_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bchk_en_o && bchk_done_i && bchk_pass_i) |=> rx_flag_o); // R6
  AST_BCHK_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bchk_en_o && !bchk_done_i) |=> bchk_en_o); // R6
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_o && !rx_clear_i) |=> rx_flag_o); // R7
  AST_SLEEP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && slp_zero_i) |=> pll_en_o); // R2
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq #(
  parameter int CODE_W   = 5,
  parameter int BASE_CYC = 1024,
  parameter int EXT_MUL  = 8,
  parameter int SIGP_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] sleep_code_i,
  input  logic              ext_sel_i,
  input  logic              pll_lock_i,
  input  logic              bchk_done_i,
  input  logic              bchk_pass_i,
  input  logic              rx_clear_i,
  output logic              sleep_o,
  output logic              pll_en_o,
  output logic              sigp_en_o,
  output logic              bchk_en_o,
  output logic              rx_flag_o
);
  localparam int LEN_W = CODE_W + $clog2(BASE_CYC) + $clog2(EXT_MUL) + 1;
  localparam int FIX_W = $clog2(SIGP_CYC) + 1;

  logic [LEN_W-1:0] len;
  logic len_zero, slp_zero, fix_zero;
  logic slp_load, slp_dec, fix_load, fix_dec;

  rx_poll_len #(
    .CODE_W(CODE_W), .BASE_CYC(BASE_CYC), .EXT_MUL(EXT_MUL), .LEN_W(LEN_W)
  ) u_len (
    .code_i(sleep_code_i), .ext_i(ext_sel_i), .len_o(len), .zero_o(len_zero)
  );

  rx_poll_dcnt #(.W(LEN_W)) u_slp_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(slp_load),
    .load_val_i(len - LEN_W'(1)), .dec_i(slp_dec), .zero_o(slp_zero)
  );

  rx_poll_dcnt #(.W(FIX_W)) u_fix_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fix_load),
    .load_val_i(FIX_W'(SIGP_CYC - 1)), .dec_i(fix_dec), .zero_o(fix_zero)
  );

  rx_poll_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i),
    .bchk_done_i(bchk_done_i), .bchk_pass_i(bchk_pass_i), .rx_clear_i(rx_clear_i),
    .len_zero_i(len_zero), .slp_zero_i(slp_zero), .fix_zero_i(fix_zero),
    .slp_load_o(slp_load), .slp_dec_o(slp_dec),
    .fix_load_o(fix_load), .fix_dec_o(fix_dec),
    .sleep_o(sleep_o), .pll_en_o(pll_en_o), .sigp_en_o(sigp_en_o),
    .bchk_en_o(bchk_en_o), .rx_flag_o(rx_flag_o)
  );
endmodule

// File: tb/sim_rx_poll_seq.sv
`timescale 1ns/1ps
module sim_rx_poll_seq;
  localparam int BASE = 4;
  localparam int EXTM = 8;
  localparam int SIGP = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] code = 5'd2;
  logic ext = 1'b0, lock = 1'b0, done = 1'b0, pass = 1'b0, clr = 1'b0;
  logic sleep_o, pll_en_o, sigp_en_o, bchk_en_o, rx_flag_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rx_poll_seq #(.CODE_W(5), .BASE_CYC(BASE), .EXT_MUL(EXTM), .SIGP_CYC(SIGP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_code_i(code), .ext_sel_i(ext),
    .pll_lock_i(lock), .bchk_done_i(done), .bchk_pass_i(pass), .rx_clear_i(clr),
    .sleep_o(sleep_o), .pll_en_o(pll_en_o), .sigp_en_o(sigp_en_o),
    .bchk_en_o(bchk_en_o), .rx_flag_o(rx_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int out_vec();
    return {27'd0, sleep_o, pll_en_o, sigp_en_o, bchk_en_o, rx_flag_o};
  endfunction

  // count cycles with sleep_o high, starting at the current negedge
  task automatic sleep_len(output int n);
    n = 0;
    while (sleep_o && n < 5000) begin
      chk($onehot0(out_vec()), "R9", out_vec(), 16);
      n++;
      @(negedge clk);
    end
  endtask

  // from the PLL phase to the bit-check window
  task automatic pll_sigp(input bit early);
    int n;
    chk(pll_en_o, "R4 pll_en after sleep", out_vec(), 8);
    if (!early) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(pll_en_o, "R4 wait for lock", out_vec(), 8);
      end
      lock = 1'b1;
    end
    @(negedge clk);
    lock = 1'b0;
    chk(sigp_en_o, "R4 sigp after lock", out_vec(), 4);
    n = 0;
    while (sigp_en_o && n < 100) begin n++; @(negedge clk); end
    chk(n == SIGP, "R5 sigp length", n, SIGP);
    chk(bchk_en_o, "R5 bchk after sigp", out_vec(), 2);
  endtask

  // fail the bit check, then measure one whole loop
  task automatic do_poll(input logic [4:0] c, input bit e, input bit early, input bit noise);
    int n, exp_n;
    exp_n = int'(c) * BASE * (e ? EXTM : 1);
    code = c; ext = e; done = 1'b1; pass = 1'b0; lock = early;
    @(negedge clk);
    done = 1'b0;
    code = ~c; ext = ~e;  // R8: ignored during sleep
    if (noise) begin done = 1'b1; pass = 1'b1; clr = 1'b1; end
    sleep_len(n);
    done = 1'b0; pass = 1'b0; clr = 1'b0;
    if (c == 0) chk(n == 0, "R3 zero code skips sleep", n, 0);
    else        chk(n == exp_n, "R2 R8 sleep length", n, exp_n);
    chk(!rx_flag_o, "R8 noise in sleep", out_vec(), 8);
    pll_sigp(early);
  endtask

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    chk(out_vec() == 0, "R1 outputs in reset", out_vec(), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    sleep_len(n);
    chk(n == 2 * BASE, "R1 first sleep", n, 2 * BASE);
    pll_sigp(1'b0);

    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 32; c++)
        do_poll(5'(c), e[0], c[0], c[1]);

    // bit-check window waits for done
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bchk_en_o, "R6 bchk waits", out_vec(), 2);
    end
    done = 1'b1; pass = 1'b1;
    @(negedge clk);
    done = 1'b0; pass = 1'b0;
    chk(rx_flag_o, "R6 pass sets rx_flag", out_vec(), 1);
    done = 1'b1; lock = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rx_flag_o, "R7 R8 rx_flag held", out_vec(), 1);
    end
    done = 1'b0; lock = 1'b0;
    code = 5'd3; ext = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    sleep_len(n);
    chk(n == 3 * BASE * EXTM, "R7 clear reloads sleep", n, 3 * BASE * EXTM);
    pll_sigp(1'b0);

    // a pass after a zero code: clear goes straight to start-up
    done = 1'b1; pass = 1'b1;
    @(negedge clk);
    done = 1'b0; pass = 1'b0;
    code = 5'd0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(pll_en_o, "R3 R7 clear with zero code", out_vec(), 8);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end
endmodule